// File: doc/BRIEF.md
# Trace Record Formatter

This block converts one captured transaction-layer packet header into a trace record for a capture memory. A header is offered with four 32-bit header dwords, an optional 32-bit PASID prefix with its valid flag, and a one-bit layout select. The block takes a copy of these inputs together with a free-running 32-bit timestamp. It then streams the record out one dword per cycle on a valid/ready interface and flags the final dword.

There are two layouts. The short layout is four dwords long. Its first dword packs selected fields of header DW0 next to an 11-bit time tag, and header DW1 to DW3 follow unchanged. The long layout is eight dwords long. It opens with an all-ones marker dword so a decoder can tell the two layouts apart. It then carries the prefix, all four header dwords, a zero dword and the full timestamp. Only one record is in flight at a time: the header port is ready again only after the last dword of the current record has been sent.

Top module: `tlp_trace_packer`

## Requirements
- R1: After reset `rec_valid` is low and `hdr_ready` is high.
- R2: A header is taken on a rising clock edge where `hdr_valid` and `hdr_ready` are both high. From the next cycle `hdr_ready` is low and `rec_valid` is high with the first dword. `hdr_ready` returns high in the cycle after the last dword's handshake, and `rec_valid` is low in that cycle.
- R3: An output dword advances only on an edge where `rec_valid` and `rec_ready` are both high. While `rec_valid` is high and `rec_ready` is low, `rec_data` and `rec_last` hold their values.
- R4: With `fmt_sel`=0 the record has 4 dwords. Dword 0 is built from header DW0 (h) and the timestamp value present at accept (t) as follows: bits 31:30 = h[30:29], bits 29:25 = h[28:24], bit 24 = h[23], bit 23 = h[19], bit 22 = h[16], bit 21 = h[13], bits 20:11 = h[9:0], bits 10:0 = t[10:0].
- R5: In the 4-dword record, dwords 1, 2 and 3 equal header DW1, DW2 and DW3 unchanged.
- R6: With `fmt_sel`=1 the record has 8 dwords, and dword 0 is 32'hFFFFFFFF.
- R7: In the 8-dword record, dword 1 is the prefix when `pfx_valid` was high at accept, and zero otherwise.
- R8: In the 8-dword record, dwords 2 to 5 are header DW0 to DW3. Dword 6 is zero. Dword 7 is the full timestamp value present at accept.
- R9: `rec_last` is high only on the final dword of a record: dword 3 of a 4-dword record and dword 7 of an 8-dword record.
- R10: Changes on the header, prefix, prefix-valid, timestamp, select and `hdr_valid` inputs while a record is being sent have no effect on that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Block can take a header |
| hdr_dw0 | input | 32 | Header dword 0 |
| hdr_dw1 | input | 32 | Header dword 1 |
| hdr_dw2 | input | 32 | Header dword 2 |
| hdr_dw3 | input | 32 | Header dword 3 |
| pfx_dw | input | 32 | PASID prefix dword |
| pfx_valid | input | 1 | Prefix present |
| fmt_sel | input | 1 | 0: 4-dword layout, 1: 8-dword layout |
| stamp | input | 32 | Free-running timestamp |
| rec_valid | output | 1 | Record dword valid |
| rec_ready | input | 1 | Sink takes the dword |
| rec_data | output | 32 | Record dword |
| rec_last | output | 1 | Final dword of the record |

## Verification
The first dword of a record is due one cycle after the header handshake. Each later dword is due one cycle after the handshake of the one before it, and `hdr_ready` returns one cycle after the last handshake. The bench drives and samples on the falling edge. It keeps a dword index that it advances only after an edge where it held `rec_ready` high. Each sample is therefore compared with the dword that must be on the bus at that point, and a stall makes the bench compare the same expected dword again. The expected timestamp is the value the bench drove in the half cycle before the accepting edge. All inputs are scrambled while the record is draining.

// File: rtl/tlp_trace_packer.sv
module tlp_trace_packer #(
  parameter int SHORT_N = 4,
  parameter int LONG_N  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_valid,
  output logic        hdr_ready,
  input  logic [31:0] hdr_dw0,
  input  logic [31:0] hdr_dw1,
  input  logic [31:0] hdr_dw2,
  input  logic [31:0] hdr_dw3,
  input  logic [31:0] pfx_dw,
  input  logic        pfx_valid,
  input  logic        fmt_sel,
  input  logic [31:0] stamp,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic [31:0] rec_data,
  output logic        rec_last
);
  localparam int IDX_W = $clog2(LONG_N);
  localparam logic [IDX_W-1:0] SHORT_END = IDX_W'(SHORT_N - 1);
  localparam logic [IDX_W-1:0] LONG_END  = IDX_W'(LONG_N - 1);

  logic             busy;
  logic             wide;
  logic [IDX_W-1:0] idx;
  logic [31:0]      h0, h1, h2, h3, pfx_q, ts_q;
  logic [31:0]      short_head;

  wire accept   = hdr_valid && !busy;
  wire beat     = busy && rec_ready;
  wire at_end   = idx == (wide ? LONG_END : SHORT_END);

  assign hdr_ready = !busy;
  assign rec_valid = busy;
  assign rec_last  = busy && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wide <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      wide <= fmt_sel;
      idx  <= '0;
    end else if (beat) begin
      if (at_end) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      h0    <= hdr_dw0;
      h1    <= hdr_dw1;
      h2    <= hdr_dw2;
      h3    <= hdr_dw3;
      pfx_q <= pfx_valid ? pfx_dw : 32'h0;
      ts_q  <= stamp;
    end
  end

  assign short_head = {h0[30:29], h0[28:24], h0[23], h0[19], h0[16], h0[13],
                       h0[9:0], ts_q[10:0]};

  always_comb begin
    rec_data = 32'h0;
    if (!wide) begin
      case (idx)
        3'd0:    rec_data = short_head;
        3'd1:    rec_data = h1;
        3'd2:    rec_data = h2;
        3'd3:    rec_data = h3;
        default: rec_data = 32'h0;
      endcase
    end else begin
      case (idx)
        3'd0:    rec_data = 32'hFFFF_FFFF;
        3'd1:    rec_data = pfx_q;
        3'd2:    rec_data = h0;
        3'd3:    rec_data = h1;
        3'd4:    rec_data = h2;
        3'd5:    rec_data = h3;
        3'd6:    rec_data = 32'h0;
        default: rec_data = ts_q;
      endcase
    end
  end
endmodule

// File: rtl/tlp_trace_packer_chk.sv
module tlp_trace_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic        hdr_ready,
  input logic        rec_valid,
  input logic        rec_ready,
  input logic [31:0] rec_data,
  input logic        rec_last
);
  logic [3:0] beats;
  logic       live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats <= '0;
      live  <= 1'b0;
    end else begin
      live <= 1'b1;
      if (rec_valid && rec_ready) beats <= rec_last ? 4'd0 : beats + 4'd1;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (hdr_ready && !rec_valid));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_ready && rec_valid));

  a_r2_record_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> (rec_valid && !hdr_ready));

  a_r2_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && rec_last) |=> (hdr_ready && !rec_valid));

  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_last)));

  a_r9_last_position: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_last) |-> (beats == 4'd3 || beats == 4'd7));

  a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && beats == 4'd7) |-> rec_last);
endmodule

bind tlp_trace_packer tlp_trace_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
  .rec_last(rec_last)
);

// File: tb/tlp_trace_packer_tb.sv
module tlp_trace_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [31:0] hdr_dw0 = '0, hdr_dw1 = '0, hdr_dw2 = '0, hdr_dw3 = '0;
  logic [31:0] pfx_dw = '0;
  logic        pfx_valid = 1'b0;
  logic        fmt_sel = 1'b0;
  logic [31:0] stamp = 32'h1234_5000;
  logic        rec_valid;
  logic        rec_ready = 1'b0;
  logic [31:0] rec_data;
  logic        rec_last;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) stamp <= stamp + 32'd1;

  tlp_trace_packer u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_dw0(hdr_dw0), .hdr_dw1(hdr_dw1), .hdr_dw2(hdr_dw2), .hdr_dw3(hdr_dw3),
    .pfx_dw(pfx_dw), .pfx_valid(pfx_valid), .fmt_sel(fmt_sel), .stamp(stamp),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .rec_last(rec_last)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_dw(input bit wide, input int i,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
      input logic [31:0] d, input logic [31:0] p, input bit pv, input logic [31:0] t);
    if (!wide) begin
      case (i)
        0: return {a[30:29], a[28:24], a[23], a[19], a[16], a[13], a[9:0], t[10:0]};
        1: return b;
        2: return c;
        default: return d;
      endcase
    end
    case (i)
      0: return 32'hFFFF_FFFF;
      1: return pv ? p : 32'h0;
      2: return a;
      3: return b;
      4: return c;
      5: return d;
      6: return 32'h0;
      default: return t;
    endcase
  endfunction

  function automatic string req_of(input bit wide, input int i);
    if (!wide) return (i == 0) ? "R4" : "R5";
    if (i == 0) return "R6";
    if (i == 1) return "R7";
    return "R8";
  endfunction

  task automatic scramble();
    hdr_dw0 = $urandom; hdr_dw1 = $urandom; hdr_dw2 = $urandom; hdr_dw3 = $urandom;
    pfx_dw = $urandom; pfx_valid = $urandom % 2; fmt_sel = $urandom % 2;
    hdr_valid = $urandom % 2;
  endtask

  task automatic send(input bit wide, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] c, input logic [31:0] d,
                      input logic [31:0] p, input bit pv, input int stall_pct);
    int n;
    int i;
    logic [31:0] t;
    n = wide ? 8 : 4;
    hdr_dw0 = a; hdr_dw1 = b; hdr_dw2 = c; hdr_dw3 = d;
    pfx_dw = p; pfx_valid = pv; fmt_sel = wide; hdr_valid = 1'b1;
    rec_ready = 1'b0;
    check(hdr_ready === 1'b1, "R2 ready before accept", {31'h0, hdr_ready}, 32'h1);
    t = stamp;
    @(posedge clk);
    @(negedge clk);
    scramble();
    i = 0;
    while (i < n) begin
      bit rdy;
      rdy = ($urandom % 100) >= stall_pct;
      rec_ready = rdy;
      check(rec_valid === 1'b1, "R2 valid during record", {31'h0, rec_valid}, 32'h1);
      check(hdr_ready === 1'b0, "R2 busy during record", {31'h0, hdr_ready}, 32'h0);
      check(rec_data === exp_dw(wide, i, a, b, c, d, p, pv, t),
            $sformatf("%s/R3/R10 dword %0d", req_of(wide, i), i),
            rec_data, exp_dw(wide, i, a, b, c, d, p, pv, t));
      check(rec_last === (i == n - 1), $sformatf("R9 last at dword %0d", i),
            {31'h0, rec_last}, {31'h0, 1'(i == n - 1)});
      @(posedge clk);
      @(negedge clk);
      scramble();
      if (rdy) i++;
    end
    hdr_valid = 1'b0;
    rec_ready = 1'b0;
    check(hdr_ready === 1'b1, "R2 ready after last", {31'h0, hdr_ready}, 32'h1);
    check(rec_valid === 1'b0, "R2 idle after last", {31'h0, rec_valid}, 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(rec_valid === 1'b0, "R1 reset valid", {31'h0, rec_valid}, 32'h0);
    check(hdr_ready === 1'b1, "R1 reset ready", {31'h0, hdr_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rec_valid === 1'b0, "R1 idle valid", {31'h0, rec_valid}, 32'h0);
    // directed corners: all-ones header short, long without and with prefix, zeros
    send(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hA5A5_5A5A, 32'h0, 1'b0, 0);
    send(1'b0, 32'h6089_2155, 32'h0F1E_0001, 32'h0400_0000, 32'h4000_8102, 32'h0, 1'b0, 50);
    send(1'b1, 32'h0100_0060, 32'h0F1E_0001, 32'h0400_0000, 32'h4000_8102, 32'hDEAD_BEEF, 1'b0, 0);
    send(1'b1, 32'h0100_0060, 32'h0F1E_0001, 32'h0400_0000, 32'h4000_8102, 32'h9100_0123, 1'b1, 60);
    send(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1, 0);
    for (int k = 0; k < 60; k++)
      send(1'($urandom % 2), $urandom, $urandom, $urandom, $urandom, $urandom,
           1'($urandom % 2), 30);
    done = 1;
    finish_run();
  end
endmodule